// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block selects which of several interrupt sources is offered to the processor. Each source has a pending flag, an enable bit, a 4-bit priority level and a 2-bit group level. Among the sources that are pending, enabled and above the processor's current priority, the one with the largest `{level, group}` key wins. The winner's index and level are offered on a valid/ready channel, and the processor takes them with `irq_ready_i`.

The block also holds the processor's interrupt status: a global enable and a 4-bit current priority. Software writes to this status do not act at once. They take effect only after two retired instruction slots, which `instr_step_i` marks. An atomic command blocks the offer for a programmed number of following instruction slots. When an offer is taken, the current priority rises to the winner's level and the winner's pending flag clears.

The offer channel follows these rules. `irq_valid_o` is driven from a register. While `irq_ready_i` is low, the offer is not held: it may move to a stronger source, or it may be withdrawn when a lockout begins. A transfer happens on a rising clock edge where `irq_valid_o` and `irq_ready_i` are both high. `irq_ready_i` has no effect while `irq_valid_o` is low.

Top module: `prio_irq_arbiter`

## Requirements
- R1: No offer is made while the effective global enable (`cur_ien_o`) is 0. Reset leaves it at 0.
- R2: A source whose `src_en_i` bit is 0 is never offered.
- R3: A source is offered only if its level is strictly greater than `cur_lvl_o`. Therefore level 0 is never offered, and a current priority of 15 blocks every source.
- R4: Among eligible sources, the largest key wins. The key is the unsigned value `{level[3:0], group[1:0]}`, with source i's level at `src_lvl_i[4i+3:4i]` and its group at `src_grp_i[2i+1:2i]`. If two keys are equal, the lower index wins.
- R5: A pulse on `req_i[i]` sets pending flag i. A transfer clears the flag of the offered source. If a request for that same source arrives in the transfer cycle, the source stays pending.
- R6: On a transfer, `cur_lvl_o` takes the offered level from the next cycle onward.
- R7: A status-word write (`psw_wr_i` with `psw_ien_i`, `psw_lvl_i`) reaches `cur_ien_o` and `cur_lvl_o` only on the second `instr_step_i` pulse after the write cycle. A new write restarts the count. No offer is made while a write is waiting.
- R8: `atomic_i` with count c blocks offers until c further `instr_step_i` pulses have occurred. A count of 0 starts no window, and counts above 4 act as 4.
- R9: Outputs are registered and reflect the state after each clock edge. Reset clears every pending flag, `irq_valid_o`, `irq_id_o`, `irq_lvl_o`, `cur_ien_o` and `cur_lvl_o`.
- R10: While `irq_ready_i` is low, the offer follows the current winner and may change or drop. `irq_ready_i` has no effect while `irq_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Request pulses, one per source |
| src_en_i | input | NUM_SRC | Per-source enable bits |
| src_lvl_i | input | 4*NUM_SRC | Per-source priority levels |
| src_grp_i | input | 2*NUM_SRC | Per-source group levels |
| instr_step_i | input | 1 | One instruction slot retired |
| psw_wr_i | input | 1 | Status-word write strobe |
| psw_ien_i | input | 1 | Written global enable |
| psw_lvl_i | input | 4 | Written current priority |
| atomic_i | input | 1 | Atomic command strobe |
| atomic_cnt_i | input | ATOM_W | Atomic window length in instructions |
| irq_valid_o | output | 1 | Offer valid |
| irq_ready_i | input | 1 | Processor takes the offer |
| irq_id_o | output | IDW | Offered source index |
| irq_lvl_o | output | 4 | Offered source level |
| cur_ien_o | output | 1 | Effective global enable |
| cur_lvl_o | output | 4 | Effective current priority |

## Verification
Some properties are checked by assertions on every cycle:
- every offer is above the current priority, comes from an enabled source and has a non-zero level;
- no offer appears during a lockout or a pending status write;
- a transfer raises the current priority;
- a transfer clears the pending flag;
- the lockout and delay counters stay within their bounds.

Other behaviour can only be shown by the bench scenarios against a reference model. This covers which source wins under ties and group tie-breaks, how many instruction slots a status write or atomic window lasts, the clamping of atomic counts, the re-pending of a source requested during its own transfer, and changes of the offer while ready is low.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 4;
  localparam int GRP_W  = 2;
  localparam int KEY_W  = PRIO_W + GRP_W;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  ien;
    prio_t lvl;
  } psw_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 8,
  parameter int IDW     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               clr_i,
  input  logic [IDW-1:0]     clr_id_i,
  output logic [NUM_SRC-1:0] pend_nxt_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic hit;
    assign hit           = clr_i && (clr_id_i == IDW'(g));
    assign pend_nxt_o[g] = (pend_q[g] & ~hit) | req_i[g];

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_nxt_o[g];
    end

    // R5: a transfer without a fresh request leaves the source idle
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !req_i[g]) |=> !pend_q[g]);
  end
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
  import irq_arb_pkg::*;
#(
  parameter int PSW_LAG  = 2,
  parameter int ATOM_MAX = 4,
  parameter int ATOM_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_step_i,
  input  logic              psw_wr_i,
  input  psw_t              psw_new_i,
  input  logic              atomic_i,
  input  logic [ATOM_W-1:0] atomic_cnt_i,
  input  logic              ack_i,
  input  prio_t             ack_lvl_i,
  output psw_t              psw_nxt_o,
  output psw_t              psw_q_o,
  output logic              gate_nxt_o,
  output logic              busy_o
);
  localparam int DW = $clog2(PSW_LAG + 1);

  psw_t              eff_q, eff_n, stg_q, stg_n;
  logic [DW-1:0]     dly_q, dly_n;
  logic [ATOM_W-1:0] lock_q, lock_n;

  always_comb begin
    eff_n  = eff_q;
    stg_n  = stg_q;
    dly_n  = dly_q;
    lock_n = lock_q;
    if (ack_i) eff_n.lvl = ack_lvl_i;
    if (psw_wr_i) begin
      stg_n = psw_new_i;
      dly_n = DW'(PSW_LAG);
    end else if (instr_step_i && dly_q != '0) begin
      dly_n = dly_q - 1'b1;
      if (dly_q == DW'(1)) eff_n = stg_q;
    end
    if (atomic_i)
      lock_n = (atomic_cnt_i > ATOM_W'(ATOM_MAX)) ? ATOM_W'(ATOM_MAX) : atomic_cnt_i;
    else if (instr_step_i && lock_q != '0)
      lock_n = lock_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q  <= '0;
      stg_q  <= '0;
      dly_q  <= '0;
      lock_q <= '0;
    end else begin
      eff_q  <= eff_n;
      stg_q  <= stg_n;
      dly_q  <= dly_n;
      lock_q <= lock_n;
    end
  end

  assign psw_nxt_o  = eff_n;
  assign psw_q_o    = eff_q;
  assign gate_nxt_o = (dly_n != '0) || (lock_n != '0);
  assign busy_o     = (dly_q != '0) || (lock_q != '0);

  // R8: lockout never exceeds its ceiling
  p_lock_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q <= ATOM_W'(ATOM_MAX));
  // R7: write delay never exceeds its length
  p_dly_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q <= DW'(PSW_LAG));
  // R7: a waiting write with no step, no new write and no transfer leaves status alone
  p_psw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q != '0 && !instr_step_i && !psw_wr_i && !ack_i) |=> $stable(eff_q));
endmodule

// File: rtl/irq_arb_core.sv
module irq_arb_core
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDW     = 3
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] lvl_i,
  input  logic [NUM_SRC*GRP_W-1:0]  grp_i,
  input  psw_t                      psw_i,
  output logic                      any_o,
  output logic [IDW-1:0]            id_o,
  output prio_t                     lvl_o
);
  logic [NUM_SRC-1:0] elig;
  logic [KEY_W-1:0]   key [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign key[g]  = {lvl_i[g*PRIO_W +: PRIO_W], grp_i[g*GRP_W +: GRP_W]};
    assign elig[g] = pend_i[g] & en_i[g] & psw_i.ien &
                     (lvl_i[g*PRIO_W +: PRIO_W] > psw_i.lvl);
  end

  logic [KEY_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    best  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!any_o || key[i] > best)) begin
        any_o = 1'b1;
        id_o  = IDW'(i);
        best  = key[i];
      end
    end
    lvl_o = best[KEY_W-1:GRP_W];
  end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int PSW_LAG  = 2,
  parameter int ATOM_MAX = 4,
  parameter int ATOM_W   = $clog2(ATOM_MAX + 1),
  parameter int IDW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC-1:0]        src_en_i,
  input  logic [NUM_SRC*4-1:0]      src_lvl_i,
  input  logic [NUM_SRC*2-1:0]      src_grp_i,
  input  logic                      instr_step_i,
  input  logic                      psw_wr_i,
  input  logic                      psw_ien_i,
  input  logic [3:0]                psw_lvl_i,
  input  logic                      atomic_i,
  input  logic [ATOM_W-1:0]         atomic_cnt_i,
  output logic                      irq_valid_o,
  input  logic                      irq_ready_i,
  output logic [IDW-1:0]            irq_id_o,
  output logic [3:0]                irq_lvl_o,
  output logic                      cur_ien_o,
  output logic [3:0]                cur_lvl_o
);
  logic               ack;
  logic [NUM_SRC-1:0] pend_nxt;
  psw_t               psw_nxt, psw_q, psw_new;
  logic               gate_nxt, stat_busy;
  logic               win_any;
  logic [IDW-1:0]     win_id;
  prio_t              win_lvl;

  assign ack     = irq_valid_o & irq_ready_i;
  assign psw_new = '{ien: psw_ien_i, lvl: psw_lvl_i};

  irq_pend_bank #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .clr_i      (ack),
    .clr_id_i   (irq_id_o),
    .pend_nxt_o (pend_nxt)
  );

  irq_status_ctl #(.PSW_LAG(PSW_LAG), .ATOM_MAX(ATOM_MAX), .ATOM_W(ATOM_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_step_i (instr_step_i),
    .psw_wr_i     (psw_wr_i),
    .psw_new_i    (psw_new),
    .atomic_i     (atomic_i),
    .atomic_cnt_i (atomic_cnt_i),
    .ack_i        (ack),
    .ack_lvl_i    (irq_lvl_o),
    .psw_nxt_o    (psw_nxt),
    .psw_q_o      (psw_q),
    .gate_nxt_o   (gate_nxt),
    .busy_o       (stat_busy)
  );

  irq_arb_core #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_arb (
    .pend_i (pend_nxt),
    .en_i   (src_en_i),
    .lvl_i  (src_lvl_i),
    .grp_i  (src_grp_i),
    .psw_i  (psw_nxt),
    .any_o  (win_any),
    .id_o   (win_id),
    .lvl_o  (win_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid_o <= 1'b0;
      irq_id_o    <= '0;
      irq_lvl_o   <= '0;
    end else begin
      irq_valid_o <= win_any & ~gate_nxt;
      irq_id_o    <= win_id;
      irq_lvl_o   <= win_lvl;
    end
  end

  assign cur_ien_o = psw_q.ien;
  assign cur_lvl_o = psw_q.lvl;

  // R1: offers only under global enable
  p_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> cur_ien_o);
  // R2: offered source was enabled when arbitrated
  p_src_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (($past(src_en_i) >> irq_id_o) & NUM_SRC'(1)) != '0);
  // R3: offered level is above the current priority
  p_lvl_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> irq_lvl_o > cur_lvl_o);
  // R3: level zero is never offered
  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> irq_lvl_o != 4'd0);
  // R7, R8: no offer while a write waits or a lockout runs
  p_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> !stat_busy);
  // R6: a transfer raises the current priority to the offered level
  p_ack_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i) |=> cur_lvl_o == $past(irq_lvl_o));
endmodule

// File: tb/test_prio_irq_arbiter.sv
module test_prio_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, en = '0;
  logic [N*4-1:0] lvl = '0;
  logic [N*2-1:0] grp = '0;
  logic          step = 1'b0, wr = 1'b0, wr_ien = 1'b0, atom = 1'b0, ready = 1'b0;
  logic [3:0]    wr_lvl = '0;
  logic [AW-1:0] atom_cnt = '0;
  logic          valid, cur_ien;
  logic [IW-1:0] id;
  logic [3:0]    olvl, cur_lvl;

  int checks = 0, errors = 0;
  string tag = "R9 reset";

  // reference state
  logic [N-1:0] m_pend = '0;
  logic         m_ien = 1'b0, m_sien = 1'b0;
  logic [3:0]   m_lvl = '0, m_slvl = '0;
  int           m_dly = 0, m_lock = 0;
  logic         e_valid = 1'b0;
  int           e_id = 0;
  logic [3:0]   e_lvl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_arbiter i_prio_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .src_en_i(en), .src_lvl_i(lvl),
    .src_grp_i(grp), .instr_step_i(step), .psw_wr_i(wr), .psw_ien_i(wr_ien),
    .psw_lvl_i(wr_lvl), .atomic_i(atom), .atomic_cnt_i(atom_cnt),
    .irq_valid_o(valid), .irq_ready_i(ready), .irq_id_o(id), .irq_lvl_o(olvl),
    .cur_ien_o(cur_ien), .cur_lvl_o(cur_lvl)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model_arbitrate();
    int best = -1;
    int bkey = 0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = {lvl[4*i +: 4], grp[2*i +: 2]};
      if (m_pend[i] && en[i] && m_ien && lvl[4*i +: 4] > m_lvl && (best < 0 || k > bkey)) begin
        best = i;
        bkey = k;
      end
    end
    e_valid = (best >= 0) && m_dly == 0 && m_lock == 0;
    e_id    = (best >= 0) ? best : 0;
    e_lvl   = 4'(bkey >> 2);
  endfunction

  function automatic void model_edge();
    if (e_valid && ready) begin
      m_pend[e_id] = 1'b0;
      m_lvl = e_lvl;
    end
    m_pend = m_pend | req;
    if (wr) begin
      m_sien = wr_ien; m_slvl = wr_lvl; m_dly = 2;
    end else if (step && m_dly != 0) begin
      m_dly--;
      if (m_dly == 0) begin m_ien = m_sien; m_lvl = m_slvl; end
    end
    if (atom) m_lock = (atom_cnt > 4) ? 4 : int'(atom_cnt);
    else if (step && m_lock != 0) m_lock--;
    model_arbitrate();
  endfunction

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      #1;
      chk("valid", int'(valid), int'(e_valid));
      chk("cur_ien", int'(cur_ien), int'(m_ien));
      chk("cur_lvl", int'(cur_lvl), int'(m_lvl));
      if (e_valid) begin
        chk("id", int'(id), e_id);
        chk("lvl", int'(olvl), int'(e_lvl));
      end
      req = '0; step = 1'b0; wr = 1'b0; atom = 1'b0;
    end
  endtask

  task automatic set_src(input int i, input logic e, input int l, input int g);
    en[i] = e;
    lvl[4*i +: 4] = 4'(l);
    grp[2*i +: 2] = 2'(g);
  endtask

  task automatic psw_write(input logic ie, input int l);
    wr = 1'b1; wr_ien = ie; wr_lvl = 4'(l);
    cyc();
    step = 1'b1; cyc();
    step = 1'b1; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    tag = "R9 reset";
    chk("valid", int'(valid), 0);
    chk("cur_ien", int'(cur_ien), 0);
    chk("cur_lvl", int'(cur_lvl), 0);

    tag = "R1 global enable off";
    set_src(0, 1'b1, 5, 0);
    req[0] = 1'b1;
    cyc(3);

    tag = "R7 status write delay";
    wr = 1'b1; wr_ien = 1'b1; wr_lvl = 4'd0; cyc();
    cyc(2);
    step = 1'b1; cyc();
    wr = 1'b1; wr_ien = 1'b1; wr_lvl = 4'd0; cyc();  // rewrite restarts count
    step = 1'b1; cyc();
    step = 1'b1; cyc();
    cyc();

    tag = "R10 offer moves while not ready";
    set_src(1, 1'b1, 7, 1);
    req[1] = 1'b1; cyc(2);

    tag = "R4 group tie-break";
    set_src(2, 1'b1, 7, 3);
    req[2] = 1'b1; cyc(2);
    set_src(5, 1'b1, 7, 3);
    set_src(2, 1'b1, 7, 3);
    req[5] = 1'b1; cyc(2);  // equal keys: lower index

    tag = "R6 transfer raises level";
    ready = 1'b1; cyc();
    tag = "R5 transfer clears pending";
    cyc(4);
    ready = 1'b0;

    tag = "R3 level zero and strict compare";
    psw_write(1'b1, 0);
    set_src(3, 1'b1, 0, 3);
    req[3] = 1'b1; cyc(2);
    ready = 1'b1; cyc(6); ready = 1'b0;
    req = 8'hFF; cyc();
    psw_write(1'b1, 15);
    cyc(2);

    tag = "R2 source disable";
    psw_write(1'b1, 0);
    set_src(4, 1'b0, 9, 0);
    req[4] = 1'b1; cyc(2);
    ready = 1'b1; cyc(8); ready = 1'b0;

    tag = "R8 atomic window clamp";
    req[0] = 1'b1; cyc();
    atom = 1'b1; atom_cnt = 3'd7; cyc();
    for (int s = 0; s < 5; s++) begin step = 1'b1; cyc(); cyc(); end
    atom = 1'b1; atom_cnt = 3'd0; cyc(2);

    tag = "R5 request during own transfer";
    ready = 1'b1; req[0] = 1'b1; cyc();
    cyc(2); ready = 1'b0;

    tag = "R4 random traffic";
    for (int c = 0; c < 4000; c++) begin
      if (c % 200 == 0) begin
        for (int i = 0; i < N; i++)
          set_src(i, ($urandom % 5) != 0, $urandom % 16, $urandom % 4);
      end
      req      = N'($urandom) & N'($urandom);
      step     = ($urandom % 2) == 0;
      ready    = ($urandom % 3) != 0;
      if ($urandom % 30 == 0) begin
        wr = 1'b1; wr_ien = ($urandom % 8) != 0; wr_lvl = 4'($urandom % 6);
      end
      if ($urandom % 50 == 0) begin
        atom = 1'b1; atom_cnt = AW'($urandom);
      end
      cyc();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule